// File: doc/BRIEF.md
# Lens Command Repeater Bridge

This block sits between a byte-oriented host register port and a lens controller link. The host writes a 32-bit command word and then sets a start bit in the control register. The bridge sends the four command bytes to the lens over a byte-wide valid/ready channel. It then records every reply byte the lens returns until the lens signals the end of the reply.

When the reply is complete, the control register shows a completion flag and the number of bytes captured. The host drains the reply through a data register. Each read of that register returns the next byte and advances an internal read pointer. A reply may be empty. While a command is in flight, further start requests are dropped.

Host register map (2-bit address): 0 = control, 1 = command word (write-only, reads as 0), 2 = reply data (read-only). Address 3 reads as 0.

Top module: `lens_cmd_bridge`

## Requirements
- R1: The command word goes to the lens least significant byte first. Bits 7:0 (command type) go first, then bits 15:8 (command code), then bits 23:16 (parameter 1), then bits 31:24 (parameter 2). The transfer uses the word held in the command register when the start request is accepted.
- R2: While `lens_tx_valid` is high and `lens_tx_ready` is low, `lens_tx_valid` stays high and `lens_tx_data` holds its value. Exactly one byte advances per cycle in which both are high.
- R3: A control write with data bit 0 set starts a transfer when no command is in flight. Control bit 0 always reads back as 0, and `lens_tx_valid` stays low while no command is in flight.
- R4: An accepted start clears the completion flag (control bit 1), the byte count (control bits 7:2) and the reply read pointer, from the next cycle on.
- R5: A start request made while a command is being sent or its reply is awaited has no effect. The bytes sent, the reply captured and the count all stay as for the original command.
- R6: Reply bytes (`lens_rx_valid`) and the end strobe (`lens_rx_end`) are taken only after the fourth command byte has been accepted and before the end strobe. At any other time they leave the control and data registers unchanged.
- R7: On `lens_rx_end`, control bit 1 becomes 1 and control bits 7:2 hold the number of bytes captured. A byte presented in the same cycle as the end strobe is included. An end strobe with no bytes gives a count of 0.
- R8: At most DEPTH reply bytes are stored. Further bytes are dropped, and the count saturates at DEPTH.
- R9: Data register reads return the stored reply bytes in arrival order, one per read. A read past the count returns 0. A read before completion returns 0 and does not advance the pointer.
- R10: The read data for a read strobe appears on `reg_rdata` in the next cycle and holds until the next read strobe.
- R11: After reset, control reads 0 and `lens_tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 8 | Registered read data |
| lens_tx_valid | output | 1 | Command byte valid |
| lens_tx_data | output | 8 | Command byte |
| lens_tx_ready | input | 1 | Lens accepts command byte |
| lens_rx_valid | input | 1 | Reply byte valid |
| lens_rx_data | input | 8 | Reply byte |
| lens_rx_end | input | 1 | End of reply |

## Verification
Each fault in the internal state shows up at a predictable point on the ports:
- A wrong byte index or shift in the sender appears within four handshakes as out-of-order or repeated command bytes on the lens channel.
- A capture window opened too early or left open too long changes the count field on the first control read after the end strobe.
- A stale read pointer, or a count that was not cleared, shows up on the first data or control read after the next start.
- A busy check that lets a second start through either restarts the command stream mid-word, or clears a count the host expects to see.

The bench drives random ready stalls and random reply lengths, including empty, exactly full and overflowing replies. It compares every byte and count against the values it predicted.

// File: rtl/lcr_pkg.sv
`timescale 1ns/1ps
package lcr_pkg;
    localparam int BYTE_W      = 8;
    localparam int CMD_BYTES   = 4;
    localparam int CMD_W       = BYTE_W * CMD_BYTES;
    localparam int CNT_FIELD_W = 6;   // width of the count field in the control register
    localparam int ADDR_W      = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/lcr_cmd_serializer.sv
`timescale 1ns/1ps
module lcr_cmd_serializer #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NBYTES*BYTE_W-1:0] word_i,
    output logic                     tx_valid_o,
    output logic [BYTE_W-1:0]        tx_data_o,
    input  logic                     tx_ready_i,
    output logic                     last_fire_o,
    output logic                     busy_o
);
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int WW    = NBYTES * BYTE_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic [WW-1:0]    shreg;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (!ser_q.active) begin
            if (start_i) begin
                ser_d.active = 1'b1;
                ser_d.idx    = '0;
                ser_d.shreg  = word_i;
            end
        end else if (tx_ready_i) begin
            ser_d.shreg = ser_q.shreg >> BYTE_W;
            if (ser_q.idx == LAST_IDX) begin
                ser_d.active = 1'b0;
                ser_d.idx    = '0;
            end else begin
                ser_d.idx = ser_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign tx_valid_o  = ser_q.active;
    assign tx_data_o   = ser_q.shreg[BYTE_W-1:0];
    assign last_fire_o = ser_q.active && tx_ready_i && (ser_q.idx == LAST_IDX);
    assign busy_o      = ser_q.active;
endmodule

// File: rtl/lcr_reply_buffer.sv
`timescale 1ns/1ps
module lcr_reply_buffer #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              arm_i,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              rx_end_i,
    input  logic              rd_adv_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              done_o,
    output logic              capturing_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic                         capturing;
        logic                         done;
        logic [CNT_W-1:0]             count;
        logic [CNT_W-1:0]             rdptr;
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
    } rb_t;

    rb_t rb_d, rb_q;
    logic have_byte;

    assign have_byte = rb_q.done && (rb_q.rdptr < rb_q.count);

    always_comb begin
        rb_d = rb_q;
        if (rd_adv_i && have_byte)
            rb_d.rdptr = rb_q.rdptr + CNT_W'(1);
        if (clear_i) begin
            rb_d.capturing = 1'b0;
            rb_d.done      = 1'b0;
            rb_d.count     = '0;
            rb_d.rdptr     = '0;
        end else if (arm_i) begin
            rb_d.capturing = 1'b1;
        end else if (rb_q.capturing) begin
            if (rx_valid_i && (rb_q.count < FULL)) begin
                rb_d.mem[rb_q.count[AW-1:0]] = rx_data_i;
                rb_d.count = rb_q.count + CNT_W'(1);
            end
            if (rx_end_i) begin
                rb_d.capturing = 1'b0;
                rb_d.done      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign rd_byte_o   = have_byte ? rb_q.mem[rb_q.rdptr[AW-1:0]] : '0;
    assign count_o     = rb_q.count;
    assign done_o      = rb_q.done;
    assign capturing_o = rb_q.capturing;
endmodule

// File: rtl/lcr_host_port.sv
`timescale 1ns/1ps
module lcr_host_port
    import lcr_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic              start_o,
    output logic [CMD_W-1:0]  cmd_word_o,
    output logic              rd_adv_o
);
    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [BYTE_W-1:0] rdata;
    } hp_t;

    hp_t hp_d, hp_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        hp_d = hp_q;
        if (reg_wr && sel == SEL_CMD)
            hp_d.cmd = reg_wdata;
        if (reg_rd) begin
            unique case (sel)
                SEL_CTRL: hp_d.rdata = {CNT_FIELD_W'(count_i), done_i, 1'b0};
                SEL_DATA: hp_d.rdata = rd_byte_i;
                default:  hp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hp_q <= '0;
        else        hp_q <= hp_d;
    end

    assign start_o    = reg_wr && (sel == SEL_CTRL) && reg_wdata[0] && !busy_i;
    assign rd_adv_o   = reg_rd && (sel == SEL_DATA);
    assign cmd_word_o = hp_q.cmd;
    assign reg_rdata  = hp_q.rdata;
endmodule

// File: rtl/lens_cmd_bridge.sv
`timescale 1ns/1ps
module lens_cmd_bridge
    import lcr_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        lens_tx_valid,
    output logic [7:0]  lens_tx_data,
    input  logic        lens_tx_ready,
    input  logic        lens_rx_valid,
    input  logic [7:0]  lens_rx_data,
    input  logic        lens_rx_end
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             start_go;
    logic [CMD_W-1:0] cmd_word;
    logic             rd_adv;
    logic             ser_busy;
    logic             last_fire;
    logic             capturing;
    logic             reply_done;
    logic [CNT_W-1:0] reply_cnt;
    logic [BYTE_W-1:0] rd_byte;
    logic             busy;

    assign busy = ser_busy || capturing;

    lcr_host_port #(.CNT_W(CNT_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy),
        .done_i     (reply_done),
        .count_i    (reply_cnt),
        .rd_byte_i  (rd_byte),
        .start_o    (start_go),
        .cmd_word_o (cmd_word),
        .rd_adv_o   (rd_adv)
    );

    lcr_cmd_serializer #(.BYTE_W(BYTE_W), .NBYTES(CMD_BYTES)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_go),
        .word_i      (cmd_word),
        .tx_valid_o  (lens_tx_valid),
        .tx_data_o   (lens_tx_data),
        .tx_ready_i  (lens_tx_ready),
        .last_fire_o (last_fire),
        .busy_o      (ser_busy)
    );

    lcr_reply_buffer #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_rbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_go),
        .arm_i       (last_fire),
        .rx_valid_i  (lens_rx_valid),
        .rx_data_i   (lens_rx_data),
        .rx_end_i    (lens_rx_end),
        .rd_adv_i    (rd_adv),
        .rd_byte_o   (rd_byte),
        .count_o     (reply_cnt),
        .done_o      (reply_done),
        .capturing_o (capturing)
    );
endmodule

// File: rtl/lens_cmd_bridge_chk.sv
`timescale 1ns/1ps
module lens_cmd_bridge_chk #(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             reg_rd,
    input logic [7:0]       reg_rdata,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] count
);
    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R3
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid);

    // R4
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done && (count == '0));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind lens_cmd_bridge lens_cmd_bridge_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (lens_tx_valid),
    .tx_ready  (lens_tx_ready),
    .tx_data   (lens_tx_data),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .start     (start_go),
    .busy      (busy),
    .done      (reply_done),
    .count     (reply_cnt)
);

// File: tb/lens_cmd_bridge_tb.sv
`timescale 1ns/1ps
module lens_cmd_bridge_tb_top;
    localparam int DEPTH = 32;
    localparam logic [1:0] A_CTRL = 2'd0, A_CMD = 2'd1, A_DATA = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        lens_tx_valid;
    logic [7:0]  lens_tx_data;
    logic        lens_tx_ready = 1'b0;
    logic        lens_rx_valid = 1'b0;
    logic [7:0]  lens_rx_data = '0;
    logic        lens_rx_end = 1'b0;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;
    logic [7:0] reply [0:63];

    always #5 clk = ~clk;

    lens_cmd_bridge #(.DEPTH(DEPTH)) dut_i (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_ctrl(input int n);
        int c = (n > DEPTH) ? DEPTH : n;
        return {c[5:0], 1'b1, 1'b0};
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    endtask

    // One full transaction; inj_send / inj_wait issue start requests while busy (R5)
    task automatic run_cmd(input logic [31:0] word, input int n, input bit end_with_byte,
                           input bit inj_send, input bit inj_wait, input bit junk_after);
        logic [7:0] v, v2;
        logic [7:0] got [0:3];
        int ngot = 0;
        int cyc = 0;
        int kept;
        for (int i = 0; i < n; i++) reply[i] = 8'($urandom);
        reg_write(A_CMD, word);
        reg_write(A_CTRL, 32'h1);
        reg_read(A_CTRL, v);
        check(v == 8'h00, "R4 ctrl after start", v, 0);
        while (ngot < 4) begin
            @(negedge clk);
            reg_wr = 1'b0;
            if (inj_send && cyc == 1) begin reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = ~word; end
            if (inj_send && cyc == 2) begin reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h1; end
            lens_tx_ready = ($urandom % 3) != 0;
            if (lens_tx_valid && lens_tx_ready) begin got[ngot] = lens_tx_data; ngot++; end
            cyc++;
        end
        @(negedge clk); lens_tx_ready = 1'b0; reg_wr = 1'b0;
        check(lens_tx_valid == 1'b0, "R3 tx idle after four bytes", lens_tx_valid, 0);
        for (int b = 0; b < 4; b++)
            check(got[b] == word[8*b +: 8], "R1 byte order", got[b], word[8*b +: 8]);
        reg_read(A_DATA, v);
        check(v == 8'h00, "R9 data read before completion", v, 0);
        if (inj_wait) reg_write(A_CTRL, 32'h1);
        for (int i = 0; i < n; i++) begin
            repeat ($urandom % 3) @(negedge clk);
            @(negedge clk); lens_rx_valid = 1'b1; lens_rx_data = reply[i];
            if (end_with_byte && i == n - 1) lens_rx_end = 1'b1;
            @(negedge clk); lens_rx_valid = 1'b0; lens_rx_end = 1'b0;
        end
        if (!(end_with_byte && n > 0)) begin
            @(negedge clk); lens_rx_end = 1'b1;
            @(negedge clk); lens_rx_end = 1'b0;
        end
        reg_read(A_CTRL, v);
        check(v == exp_ctrl(n), "R7/R8 ctrl after reply", v, exp_ctrl(n));
        if (junk_after) begin
            @(negedge clk); lens_rx_valid = 1'b1; lens_rx_data = 8'hEE;
            @(negedge clk); lens_rx_end = 1'b1;
            @(negedge clk); lens_rx_valid = 1'b0; lens_rx_end = 1'b0;
            reg_read(A_CTRL, v2);
            check(v2 == exp_ctrl(n), "R6 rx while idle ignored", v2, exp_ctrl(n));
        end
        kept = (n > DEPTH) ? DEPTH : n;
        for (int i = 0; i < kept + 2; i++) begin
            reg_read(A_DATA, v);
            if (i < kept) check(v == reply[i], "R9 reply byte", v, reply[i]);
            else          check(v == 8'h00, "R9 read past count", v, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, hold;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(lens_tx_valid == 1'b0, "R11 tx_valid after reset", lens_tx_valid, 0);
        reg_read(A_CTRL, v);
        check(v == 8'h00, "R11 ctrl after reset", v, 0);
        // R10: value holds with no further read strobe
        reg_read(A_CMD, v);
        check(v == 8'h00, "R10 cmd register reads zero", v, 0);
        // R3: bit0 clear does not start
        reg_write(A_CTRL, 32'h0);
        @(negedge clk);
        check(lens_tx_valid == 1'b0, "R3 write without bit0", lens_tx_valid, 0);

        run_cmd(32'h04030201, 0, 0, 0, 0, 1);        // empty reply, R7
        run_cmd(32'hA5C3_5A3C, 1, 1, 0, 0, 0);       // single byte with end
        run_cmd(32'hDEADBEEF, 5, 0, 1, 1, 1);        // busy starts ignored, R5
        run_cmd(32'h11223344, DEPTH, 1, 0, 0, 0);    // exactly full
        run_cmd(32'h0F0E0D0C, DEPTH + 5, 0, 0, 1, 0);// overflow, R8

        // R10: rdata holds when no strobe
        reg_read(A_CTRL, hold);
        repeat (3) @(negedge clk);
        check(reg_rdata == hold, "R10 rdata hold", reg_rdata, hold);
        reg_read(A_CTRL, v);
        check(v[0] == 1'b0, "R3 ctrl bit0 reads zero", v[0], 0);

        for (int t = 0; t < 20; t++)
            run_cmd($urandom, $urandom % (DEPTH + 4), $urandom % 2,
                    $urandom % 2, $urandom % 2, $urandom % 2);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule